// File: doc/BRIEF.md
# Sequential Logical Shifter with Stream Handshakes

This block shifts an 8-bit word left or right by a requested number of bit positions. Zeros fill the vacated positions. It does not use a combinational barrel shifter. It moves the word one position per clock inside a small state machine. A valid/ready handshake controls the inputs, and a second valid/ready handshake controls the result. Because of this, the block can sit between a producer and a consumer that each stall for any number of cycles.

A request is made of three fields: a data word, a shift amount and a direction bit. The request is taken on a clock edge where `in_valid` and `in_ready` are both high. While a request is being shifted or its result is waiting, `in_ready` stays low. Nothing on the input side is captured during that time.

When the shift is done, `out_valid` rises and `out_data` holds the result. Both stay unchanged until the consumer raises `out_ready`. That handshake edge sends the block back to idle, and `in_ready` rises again. There is exactly one transaction in flight at a time, so back-pressure from the consumer passes straight through to the producer.

Top module: `shf_seq_top`

## Requirements
- R1: During reset and on the first cycle after reset, `in_ready` is 1 and `out_valid` is 0.
- R2: With `in_dir` = 1 the result is a logical right shift with zero fill, so 13 shifted by 2 gives 3.
- R3: With `in_dir` = 0 the result is a logical left shift truncated to 8 bits, so 3 shifted by 4 gives 48.
- R4: A shift amount of 0 returns the captured data unchanged in either direction.
- R5: Any shift amount of 8 or more, up to the largest value of the 4-bit `in_amt` field, gives a result of 0 in either direction.
- R6: After the edge that accepts a request, `in_ready` stays 0 until the block has returned to idle.
- R7: Once `out_valid` is 1, it stays 1 and `out_data` stays stable on every edge where `out_ready` is 0.
- R8: `out_valid` becomes 1 exactly min(amount, 8) + 1 clock edges after the accepting edge.
- R9: On the edge after an output handshake (`out_valid` and `out_ready` both 1), `out_valid` is 0 and `in_ready` is 1.
- R10: Values driven on `in_valid`, `in_data`, `in_amt` and `in_dir` while `in_ready` is 0 do not change the pending result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present on the input fields |
| in_ready | output | 1 | The block is idle and accepts a request |
| in_data | input | 8 | Word to be shifted |
| in_amt | input | 4 | Number of bit positions to shift |
| in_dir | input | 1 | 1 = right shift, 0 = left shift |
| out_valid | output | 1 | A result is held on `out_data` |
| out_ready | input | 1 | The consumer takes the result |
| out_data | output | 8 | Shifted word |

## Verification
Each request has its own due time. The result must appear min(amount, 8) + 1 edges after the accepting edge, and idle must return one edge after the output handshake. The bench changes inputs on falling edges and samples on falling edges. It counts the edges between acceptance and the first sample that shows `out_valid`, and compares that count with the formula. During those edges it also checks that `in_ready` stays low. It then holds `out_ready` low for a number of cycles that depends on the request, checking on each one that the result stays unchanged. On the falling edge after the handshake edge, it checks that the block is idle again.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } shf_state_e;

  localparam logic DIR_LEFT  = 1'b0;
  localparam logic DIR_RIGHT = 1'b1;

endpackage

// File: rtl/shf_ctrl.sv
module shf_ctrl
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AMT_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [AMT_W-1:0]              in_amt,
  input  logic                          out_ready,
  output logic                          in_ready,
  output logic                          out_valid,
  output logic                          load_en,
  output logic                          step_en,
  output logic                          fin_en
);

  localparam int unsigned CNT_W  = $clog2(DATA_W + 1);
  localparam int unsigned WIDE_W = ((AMT_W > CNT_W) ? AMT_W : CNT_W) + 1;

  shf_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, load_cnt;
  logic [WIDE_W-1:0] amt_wide;
  logic              accept;
  logic              cnt_zero;

  // Amounts at or beyond the word width are clamped: shifting DATA_W
  // single positions already empties the word.
  always_comb begin
    amt_wide = WIDE_W'(in_amt);
    if (amt_wide >= WIDE_W'(DATA_W)) begin
      load_cnt = CNT_W'(DATA_W);
    end else begin
      load_cnt = CNT_W'(amt_wide);
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign accept    = in_valid && in_ready;
  assign cnt_zero  = (cnt_q == '0);
  assign load_en   = accept;
  assign step_en   = (state_q == ST_RUN) && !cnt_zero;
  assign fin_en    = (state_q == ST_RUN) && cnt_zero;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_RUN;
          cnt_d   = load_cnt;
        end
      end
      ST_RUN: begin
        if (cnt_zero) begin
          state_d = ST_DONE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_DONE: begin
        if (out_ready) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/shf_datapath.sv
module shf_datapath
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_dir,
  output logic [DATA_W-1:0] work
);

  logic [DATA_W-1:0] work_q;
  logic [DATA_W-1:0] stepped;
  logic              dir_q;

  // One-position step: each bit takes its upper or lower neighbour,
  // with zero entering at the vacated end.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic from_hi;
    logic from_lo;
    if (b == DATA_W - 1) begin : g_top
      assign from_hi = 1'b0;
    end else begin : g_mid_hi
      assign from_hi = work_q[b+1];
    end
    if (b == 0) begin : g_bot
      assign from_lo = 1'b0;
    end else begin : g_mid_lo
      assign from_lo = work_q[b-1];
    end
    assign stepped[b] = (dir_q == DIR_RIGHT) ? from_hi : from_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      dir_q  <= DIR_LEFT;
    end else if (load_en) begin
      work_q <= in_data;
      dir_q  <= in_dir;
    end else if (step_en) begin
      work_q <= stepped;
    end
  end

  assign work = work_q;

endmodule

// File: rtl/shf_out_reg.sv
module shf_out_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin_en,
  input  logic [DATA_W-1:0] work,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (fin_en) begin
      hold_q <= work;
    end
  end

  assign out_data = hold_q;

endmodule

// File: rtl/shf_seq_top.sv
module shf_seq_top #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AMT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AMT_W-1:0]  in_amt,
  input  logic              in_dir,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic              load_en;
  logic              step_en;
  logic              fin_en;
  logic [DATA_W-1:0] work;

  shf_ctrl #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_amt    (in_amt),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load_en   (load_en),
    .step_en   (step_en),
    .fin_en    (fin_en)
  );

  shf_datapath #(
    .DATA_W (DATA_W)
  ) i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .step_en (step_en),
    .in_data (in_data),
    .in_dir  (in_dir),
    .work    (work)
  );

  shf_out_reg #(
    .DATA_W (DATA_W)
  ) i_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin_en   (fin_en),
    .work     (work),
    .out_data (out_data)
  );

endmodule

// File: rtl/shf_seq_chk.sv
module shf_seq_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AMT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [AMT_W-1:0]  in_amt,
  input logic              in_dir,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);

  localparam int unsigned LAT_W = $clog2(DATA_W + 2) + 1;

  logic [LAT_W-1:0]  lat_q;
  logic [LAT_W-1:0]  want_lat_q;
  logic              big_q;
  logic              zero_q;
  logic [DATA_W-1:0] data_q;
  logic              acc;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q      <= '0;
      want_lat_q <= '0;
      big_q      <= 1'b0;
      zero_q     <= 1'b0;
      data_q     <= '0;
    end else if (acc) begin
      lat_q      <= '0;
      big_q      <= (int'(in_amt) >= int'(DATA_W));
      zero_q     <= (in_amt == '0);
      data_q     <= in_data;
      want_lat_q <= (int'(in_amt) >= int'(DATA_W)) ? LAT_W'(DATA_W + 1)
                                                    : LAT_W'(int'(in_amt) + 1);
    end else if (!out_valid && !lat_q[LAT_W-1]) begin
      lat_q <= lat_q + LAT_W'(1);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (in_ready && !out_valid);
    end
  end

  p_no_mix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !in_ready);

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == want_lat_q));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  p_wide_amount_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && big_q) |-> (out_data == '0));

  p_amount_zero_passes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && zero_q) |-> (out_data == data_q));

endmodule

bind shf_seq_top shf_seq_chk #(
  .DATA_W (DATA_W),
  .AMT_W  (AMT_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_amt    (in_amt),
  .in_dir    (in_dir),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_shf_seq_top.sv
module test_shf_seq_top;

  localparam int CLK_P    = 10;
  localparam int DW       = 8;
  localparam int AW       = 4;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic [AW-1:0] in_amt = '0;
  logic          in_dir = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  shf_seq_top #(.DATA_W(DW), .AMT_W(AW)) i_shf_seq_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_amt    (in_amt),
    .in_dir    (in_dir),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input int d, input int a, input bit dir);
    if (a >= DW) return 0;
    if (dir) return d >> a;
    return (d << a) & ((1 << DW) - 1);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  task automatic run_txn(input int d, input int a, input bit dir,
                         input int gap, input int hold);
    int exp_val, exp_lat, lat;
    string tag;
    exp_val = model(d, a, dir);
    exp_lat = ((a >= DW) ? DW : a) + 1;
    if (a >= DW) tag = "R5";
    else if (a == 0) tag = "R4";
    else if (dir) tag = "R2";
    else tag = "R3";
    repeat (gap) @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(d);
    in_amt   = AW'(a);
    in_dir   = dir;
    check(in_ready == 1'b1, "R9 idle before request", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    // R10: garbage held on the input side while busy
    in_valid = 1'b1;
    in_data  = ~DW'(d);
    in_amt   = AW'(a + 3);
    in_dir   = ~dir;
    lat = 0;
    while (1) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (out_valid || lat > DW + 4) break;
      check(in_ready == 1'b0, "R6 in_ready low while busy", int'(in_ready), 0);
    end
    check(lat == exp_lat, "R8 result latency", lat, exp_lat);
    check(in_ready == 1'b0, "R6 in_ready low while result held", int'(in_ready), 0);
    for (int h = 0; h < hold; h++) begin
      @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
      check(out_data == DW'(exp_val), "R7 data stable", int'(out_data), exp_val);
    end
    check(out_data == DW'(exp_val), {tag, " R10 shift result"}, int'(out_data), exp_val);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b0;
    check(out_valid == 1'b0, "R9 valid dropped", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9 ready returned", int'(in_ready), 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

    // directed values from the requirements
    run_txn(13, 2, 1'b1, 0, 0);   // R2
    run_txn(3, 4, 1'b0, 1, 2);    // R3
    run_txn(21, 0, 1'b0, 0, 1);   // R4
    run_txn(21, 0, 1'b1, 2, 0);   // R4
    run_txn(255, 8, 1'b1, 0, 0);  // R5
    run_txn(255, 15, 1'b0, 0, 3); // R5
    run_txn(128, 7, 1'b1, 0, 0);  // R2 boundary
    run_txn(1, 7, 1'b0, 0, 0);    // R3 boundary

    // near-exhaustive sweep with varying stalls on both sides
    for (int d = 0; d < 256; d += 5) begin
      for (int a = 0; a < (1 << AW); a++) begin
        for (int dir = 0; dir < 2; dir++) begin
          run_txn(d, a, dir[0], (d + a) % 3, (a + dir) % 4);
        end
      end
    end
    summary();
  end

endmodule